// File: doc/BRIEF.md
# Memory Page Protection Checker

This block sits between a group of requesters and a 32 KB local memory. It checks every access against permission attributes kept for each page before the access reaches the array. Each request carries a requester ID, a privilege mode, a byte address, a read/write flag and a flag that marks a direct CPU access as opposed to a DMA or system-master access. The address is split into 16 pages of 2 KB, and each page has a 7-bit attribute: one allow bit for each of the six requester IDs plus a "local" bit.

An allowed access passes to the memory port unchanged, and its read data comes straight back. A denied access is blocked in the same cycle: the memory enable and write enable stay low, and the read data is forced to zero. One cycle after the denied access, the block latches the requester ID, the address, the access direction and the privilege into a fault status and pulses an event line toward the interrupt controller.

A small configuration port writes page attributes and clears the fault status. If a second fault arrives while the status is still valid, the first fault's details are kept and a sticky overflow flag is set.

Top module: `mpp_guard`

## Requirements
- R1: For an ID from 0 to 5, the decision uses the pair {allow bit `cfg_attr[id]`, local bit `cfg_attr[6]`} of the addressed page (page = `req_addr[14:11]`). 00 denies, 01 admits only direct accesses (`req_direct`=1), 10 admits only DMA/system-master accesses (`req_direct`=0), and 11 admits all accesses.
- R2: A request with requester ID 6 or 7 is always denied.
- R3: An allowed request drives `mem_en`=1, `mem_we`=`req_write`, and passes `mem_addr`/`mem_wdata` through in the same cycle. A denied request keeps `mem_en` and `mem_we` at 0.
- R4: `rsp_rdata` equals `mem_rdata` for an allowed read, and is all zeros for a denied request and for any write.
- R5: `fault_evt` is high for exactly the one cycle after each denied request, including a denial that overflows.
- R6: When the status is not valid, or is being cleared in the same cycle, a denied request sets `flt_valid` on the next cycle with its ID, full address, write flag and privilege. The privilege is recorded as user (0) for IDs 3 and 4, whatever `req_priv` says.
- R7: While `flt_valid`=1 and no clear is given, the captured fields hold. A further denial sets the sticky `flt_ovf`.
- R8: `cfg_clr` with no denial in the same cycle zeroes `flt_valid`, `flt_ovf` and the fields on the next cycle. With a denial in the same cycle, that denial is captured fresh with `flt_ovf`=0.
- R9: After reset, every page attribute is all ones (every access permitted), and `flt_valid`, `flt_ovf` and `fault_evt` are 0.
- R10: A write on `cfg_we` to page `cfg_page` with `cfg_attr` takes effect on the next cycle. A request in the same cycle is checked against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_id | input | 3 | Requester ID |
| req_priv | input | 1 | Privilege mode (1 supervisor, 0 user) |
| req_addr | input | 15 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_direct | input | 1 | 1 direct CPU access, 0 DMA/system master |
| req_wdata | input | 32 | Write data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| rsp_rdata | output | 32 | Read data returned to requester |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_page | input | 4 | Page to write |
| cfg_attr | input | 7 | Attribute: [5:0] per-ID allow, [6] local |
| cfg_clr | input | 1 | Clear fault status |
| fault_evt | output | 1 | One-cycle fault event |
| flt_valid | output | 1 | Fault status valid |
| flt_ovf | output | 1 | Sticky overflow |
| flt_id | output | 3 | Captured requester ID |
| flt_addr | output | 15 | Captured address |
| flt_write | output | 1 | Captured access direction |
| flt_priv | output | 1 | Captured privilege |

## Verification
The memory-side signals and `rsp_rdata` are combinational on the request, so the bench reads them 1 ns after it drives the inputs, within the same cycle. The event, the status flags and the captured fields come from a single register stage, so they are compared 1 ns after the following rising edge, against a bench model updated at that edge. An attribute write is checked in the same way: a request issued alongside the write is judged by the old value, and one issued on the next cycle is judged by the new value.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

  // Permission rule: direct CPU accesses are governed by the local bit,
  // DMA/system-master accesses by the requester's allow bit.
  function automatic logic perm_ok(input logic aid_bit, input logic local_bit,
                                   input logic direct);
    return direct ? local_bit : aid_bit;
  endfunction

  // Peripheral masters (IDs 3 and 4) always run in user mode.
  function automatic logic eff_priv(input int id, input logic priv);
    return (id == 3 || id == 4) ? 1'b0 : priv;
  endfunction

endpackage

// File: rtl/mpp_attr_regs.sv
module mpp_attr_regs #(
  parameter int NPAGES  = 16,
  parameter int NUM_IDS = 6,
  localparam int SEL_W  = $clog2(NPAGES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_page,
  input  logic [NUM_IDS:0]                 wr_data,
  output logic [NPAGES-1:0][NUM_IDS:0]     attr_q
);
  for (genvar p = 0; p < NPAGES; p++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)
        attr_q[p] <= '1;
      else if (wr_en && wr_page == SEL_W'(p))
        attr_q[p] <= wr_data;
    end
  end
endmodule

// File: rtl/mpp_decide.sv
module mpp_decide #(
  parameter int NUM_IDS = 6,
  parameter int ID_W    = 3
) (
  input  logic              valid,
  input  logic [ID_W-1:0]   id,
  input  logic              direct,
  input  logic [NUM_IDS:0]  attr,
  output logic              allow,
  output logic              deny
);
  logic id_ok, aid_bit;
  always_comb begin
    id_ok   = int'(id) < NUM_IDS;
    aid_bit = 1'b0;
    for (int i = 0; i < NUM_IDS; i++)
      if (int'(id) == i) aid_bit = attr[i];
    allow = valid && id_ok && mpp_pkg::perm_ok(aid_bit, attr[NUM_IDS], direct);
    deny  = valid && !allow;
  end
endmodule

// File: rtl/mpp_fault_cap.sv
module mpp_fault_cap #(
  parameter int ADDR_W = 15,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny,
  input  logic [ID_W-1:0]   id,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              priv,
  input  logic              clr,
  output logic              evt,
  output logic              valid,
  output logic              ovf,
  output logic [ID_W-1:0]   cap_id,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_wr,
  output logic              cap_priv
);
  logic take_new;
  assign take_new = deny && (!valid || clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt <= 1'b0; valid <= 1'b0; ovf <= 1'b0;
      cap_id <= '0; cap_addr <= '0; cap_wr <= 1'b0; cap_priv <= 1'b0;
    end else begin
      evt <= deny;
      if (take_new) begin
        valid <= 1'b1; ovf <= 1'b0;
        cap_id <= id; cap_addr <= addr; cap_wr <= wr; cap_priv <= priv;
      end else if (deny) begin
        ovf <= 1'b1;
      end else if (clr) begin
        valid <= 1'b0; ovf <= 1'b0;
        cap_id <= '0; cap_addr <= '0; cap_wr <= 1'b0; cap_priv <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpp_guard.sv
module mpp_guard #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_OFF_W = 11,
  parameter int DATA_W     = 32,
  parameter int ID_W       = 3,
  parameter int NUM_IDS    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ID_W-1:0]              req_id,
  input  logic                         req_priv,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         req_write,
  input  logic                         req_direct,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         mem_en,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic [DATA_W-1:0]            rsp_rdata,
  input  logic                         cfg_we,
  input  logic [ADDR_W-PAGE_OFF_W-1:0] cfg_page,
  input  logic [NUM_IDS:0]             cfg_attr,
  input  logic                         cfg_clr,
  output logic                         fault_evt,
  output logic                         flt_valid,
  output logic                         flt_ovf,
  output logic [ID_W-1:0]              flt_id,
  output logic [ADDR_W-1:0]            flt_addr,
  output logic                         flt_write,
  output logic                         flt_priv
);
  localparam int PAGE_W = ADDR_W - PAGE_OFF_W;
  localparam int NPAGES = 1 << PAGE_W;

  logic [NPAGES-1:0][NUM_IDS:0] attr_q;
  logic [PAGE_W-1:0]            page_w;
  logic                         allow_w, deny_w, priv_w;

  assign page_w = req_addr[ADDR_W-1:PAGE_OFF_W];
  assign priv_w = mpp_pkg::eff_priv(int'(req_id), req_priv);

  mpp_attr_regs #(.NPAGES(NPAGES), .NUM_IDS(NUM_IDS)) u_attr (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_page(cfg_page),
    .wr_data(cfg_attr), .attr_q(attr_q)
  );

  mpp_decide #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_dec (
    .valid(req_valid), .id(req_id), .direct(req_direct),
    .attr(attr_q[page_w]), .allow(allow_w), .deny(deny_w)
  );

  mpp_fault_cap #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .deny(deny_w), .id(req_id), .addr(req_addr),
    .wr(req_write), .priv(priv_w), .clr(cfg_clr), .evt(fault_evt),
    .valid(flt_valid), .ovf(flt_ovf), .cap_id(flt_id), .cap_addr(flt_addr),
    .cap_wr(flt_write), .cap_priv(flt_priv)
  );

  assign mem_en    = allow_w;
  assign mem_we    = allow_w && req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign rsp_rdata = (allow_w && !req_write) ? mem_rdata : '0;
endmodule

// File: rtl/mpp_guard_chk.sv
module mpp_guard_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 15,
  parameter int ID_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              deny_w,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              cfg_clr,
  input logic              fault_evt,
  input logic              flt_valid,
  input logic              flt_ovf,
  input logic [ADDR_W-1:0] flt_addr,
  input logic [ID_W-1:0]   flt_id
);
  a_r3_deny_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    deny_w |-> !mem_en && !mem_we);
  a_r3_we_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> req_valid && req_write);
  a_r4_deny_zero: assert property (@(posedge clk) disable iff (!rst_n)
    deny_w |-> rsp_rdata == '0);
  a_r5_evt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    deny_w |=> fault_evt);
  a_r5_evt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !deny_w |=> !fault_evt);
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    deny_w |=> flt_valid);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !cfg_clr |=> flt_valid && $stable(flt_addr) && $stable(flt_id));
  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !cfg_clr && deny_w |=> flt_ovf);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr && !deny_w |=> !flt_valid && !flt_ovf);
endmodule

bind mpp_guard mpp_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .deny_w(deny_w), .mem_en(mem_en), .mem_we(mem_we), .rsp_rdata(rsp_rdata),
  .cfg_clr(cfg_clr), .fault_evt(fault_evt), .flt_valid(flt_valid),
  .flt_ovf(flt_ovf), .flt_addr(flt_addr), .flt_id(flt_id)
);

// File: tb/tb_mpp_guard.sv
`timescale 1ns/1ps
module tb_mpp_guard;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_priv = 0, req_write = 0, req_direct = 0;
  logic [2:0] req_id = 0;
  logic [14:0] req_addr = 0;
  logic [31:0] req_wdata = 0, mem_rdata = 0;
  logic mem_en, mem_we, fault_evt, flt_valid, flt_ovf, flt_write, flt_priv;
  logic [14:0] mem_addr, flt_addr;
  logic [31:0] mem_wdata, rsp_rdata;
  logic [2:0] flt_id;
  logic cfg_we = 0, cfg_clr = 0;
  logic [3:0] cfg_page = 0;
  logic [6:0] cfg_attr = 0;

  always #2 clk = ~clk;

  mpp_guard dut (.*);

  int vecs = 0, errs = 0;
  bit [6:0] m_attr [16];
  bit m_valid, m_ovf, m_evt, m_wr, m_priv;
  bit [2:0] m_id;
  bit [14:0] m_addr;

  function automatic bit exp_ok(bit [6:0] a, int id, bit dir);
    if (id > 5) return 0;
    case ({a[id], a[6]})
      2'b00: return 0;
      2'b01: return dir;
      2'b10: return !dir;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit ok, den, bclr;
    bit [6:0] a;
    a  = m_attr[req_addr[14:11]];
    ok = req_valid && exp_ok(a, int'(req_id), req_direct);
    den = req_valid && !ok;
    bclr = cfg_clr;
    #1;
    chk({tag, " mem_en"}, 32'(mem_en), 32'(ok));
    chk({tag, " mem_we (R3)"}, 32'(mem_we), 32'(ok && req_write));
    if (ok) chk("R3 mem_addr", 32'(mem_addr), 32'(req_addr));
    chk({tag, " rsp_rdata (R4)"}, rsp_rdata, (ok && !req_write) ? mem_rdata : 32'h0);
    @(posedge clk);
    m_evt = den;
    if (den && (!m_valid || bclr)) begin
      m_valid = 1; m_ovf = 0; m_id = req_id; m_addr = req_addr; m_wr = req_write;
      m_priv = (req_id == 3 || req_id == 4) ? 1'b0 : req_priv;
    end else if (den) m_ovf = 1;
    else if (bclr) begin
      m_valid = 0; m_ovf = 0; m_id = 0; m_addr = 0; m_wr = 0; m_priv = 0;
    end
    if (cfg_we) m_attr[cfg_page] = cfg_attr;
    #1;
    chk("R5 fault_evt", 32'(fault_evt), 32'(m_evt));
    chk("R6/R8 flt_valid", 32'(flt_valid), 32'(m_valid));
    chk("R7 flt_ovf", 32'(flt_ovf), 32'(m_ovf));
    chk("R6 flt_id", 32'(flt_id), 32'(m_id));
    chk("R6 flt_addr", 32'(flt_addr), 32'(m_addr));
    chk("R6 flt_write", 32'(flt_write), 32'(m_wr));
    chk("R6 flt_priv", 32'(flt_priv), 32'(m_priv));
    @(negedge clk);
    cfg_we = 0; cfg_clr = 0; req_valid = 0;
  endtask

  task automatic req(bit [2:0] id, bit [14:0] ad, bit wr, bit dir, bit pv);
    req_valid = 1; req_id = id; req_addr = ad; req_write = wr;
    req_direct = dir; req_priv = pv; req_wdata = $urandom; mem_rdata = $urandom;
  endtask

  task automatic setpage(bit [3:0] p, bit [6:0] a);
    cfg_we = 1; cfg_page = p; cfg_attr = a; step("R10 cfg");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) m_attr[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R9 flt_valid", 32'(flt_valid), 0);
    chk("R9 flt_ovf", 32'(flt_ovf), 0);
    chk("R9 fault_evt", 32'(fault_evt), 0);
    // R9: every page permits every ID after reset
    for (int p = 0; p < 16; p++) begin
      req(3'(p % 6), 15'(p * 2048 + 5), p[0], p[1], 1); step("R9");
    end
    // R1: each encoding, direct and DMA, ID 2 on page 1
    for (int e = 0; e < 4; e++) begin
      setpage(1, {e[0], 6'b0} | (e[1] ? 7'b000_0100 : 7'b0));
      req(2, 15'h0810, 0, 1, 1); step("R1 direct");
      req(2, 15'h0814, 1, 0, 1); step("R1 dma");
    end
    // R2: invalid IDs on an all-ones page
    cfg_clr = 1; step("R8 clear");
    req(6, 15'h0100, 0, 0, 1); step("R2 id6");
    req(7, 15'h0104, 1, 1, 0); step("R2 id7 overflow R7");
    cfg_clr = 1; step("R8 clear");
    // R6: peripheral ID recorded as user
    setpage(3, 7'b0);
    req(4, 15'h1ABC, 1, 0, 1); step("R6 periph");
    req(0, 15'h1800, 0, 1, 1); step("R7 overflow");
    // R8: clear with simultaneous denial captures fresh
    cfg_clr = 1; req(1, 15'h1900, 0, 0, 1); step("R8 clr+deny");
    // R10: same-cycle write uses old attribute
    setpage(5, 7'h7F);
    cfg_we = 1; cfg_page = 5; cfg_attr = 7'b0; req(0, 15'h2800, 0, 0, 1); step("R10 old");
    req(0, 15'h2804, 0, 0, 1); step("R10 new");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        cfg_we = 1; cfg_page = 4'($urandom); cfg_attr = 7'($urandom);
      end
      if ($urandom_range(0, 11) == 0) cfg_clr = 1;
      if ($urandom_range(0, 3) != 0)
        req(3'($urandom), 15'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      step("R1 rand");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule